// File: doc/BRIEF.md
# Quad DAC SPI Register Interface

This block is the digital front end of a four-channel digital-to-analog converter. A host talks to it as an SPI slave in mode 1 (SCLK idles low, MOSI is sampled on the falling edge, MISO changes on the rising edge). The block decodes fixed 24-bit command frames and uses them to write the per-channel code, coarse gain, fine gain and offset registers, or to run one of the special commands: no-operation, configuration write, clear-to-midscale and load. All SPI pins are synchronised to the system clock. Every register state change happens in the system clock domain.

Any register can be read back in two frames. The first frame carries the read flag and the address. The next frame, whatever it carries, shifts the captured register word out on MISO. The converter side gets one right-justified code bus per channel and a one-cycle update pulse per channel. Both are refreshed only by the load command. The update pulse is a push-only valid with no ready: the converter must take the codes in the cycle the pulse is high, because the block never stalls. Code resolution is a parameter, either 16 or 14 bits.

Top module: `quad_dac_spi_regs`

## Requirements
- R1: A frame is 24 bits, sent MSB first. Bit 23 is the read flag (1 = read), bits 22:16 are the register address and bits 15:0 are the payload. The frame takes effect once, when CS rises, and only if exactly 24 falling SCLK edges were counted while CS was low.
- R2: A frame with any bit count other than 24 changes no register, no output and no pending readback word.
- R3: Address bits 22:19 select a function and bits 18:16 select a channel. Function 2 is the channel code, 3 is coarse gain, 4 is fine gain and 5 is offset. Channels 0 to 3 exist. Writes to channels 4 to 7, or to functions 1 and 6 to 15, are dropped, and those addresses read back as zero.
- R4: With RES = 14, the code occupies payload bits 15:2. Bits 1:0 are ignored on write and read back as zero. The channel output bus carries the RES-bit code right-justified.
- R5: Registers narrower than 16 bits keep only the low payload bits and read back zero-extended. Offset keeps bits 7:0 (two's complement, -128 to +127). Fine gain keeps bits 5:0 (two's complement, -32 to +31). Coarse gain keeps bits 1:0.
- R6: Writing address 0x04 (clear) sets all four code registers to midscale, word 0x8000 (offset binary). The code buses stay unchanged until a load.
- R7: Writing address 0x05 (load) raises all four update pulses together for exactly one cycle, and in that cycle each code bus takes its channel's code register. The code buses change at no other time.
- R8: A read frame changes no register and triggers no command. The frame after it shifts {8'h00, word} out on MISO, MSB first, where word is the addressed register as it stood at the end of the read frame. After a committed write frame, the next frame shifts out zeros.
- R9: Address 0x01 stores a 16-bit configuration word and reads it back. Address 0x00 does nothing and reads back as zero.
- R10: After reset every code register and code bus is at midscale, gains, offsets and configuration are zero, update pulses are low, and MISO is low whenever CS is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idles low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host, low while CS is high |
| dac_code | output | NUM_CH*RES | Per-channel right-justified code, channel c at bits c*RES +: RES |
| dac_update | output | NUM_CH | Per-channel one-cycle update pulse (valid, no ready) |

## Verification
The bench builds two copies side by side and feeds both the same SPI pin activity. One copy uses RES = 16 and the other RES = 14, both with four channels. The full-width copy exposes every payload bit through code readback and the output bus. The narrow copy shows the dropped low bits, the left-justified readback and the right-justified bus from the same stimulus. Random frames also hit unused function groups, missing channels 4 to 7 and truncated or over-long frames, so the ignore paths are exercised at both widths.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int FRAME_W = 24;
  localparam int WORD_W  = 16;

  // function groups, address bits 6:3
  localparam logic [3:0] GRP_SPECIAL = 4'd0;
  localparam logic [3:0] GRP_CODE    = 4'd2;
  localparam logic [3:0] GRP_COARSE  = 4'd3;
  localparam logic [3:0] GRP_FINE    = 4'd4;
  localparam logic [3:0] GRP_OFFSET  = 4'd5;

  // special commands, channel field of group 0
  localparam logic [2:0] SP_NOP    = 3'd0;
  localparam logic [2:0] SP_CONFIG = 3'd1;
  localparam logic [2:0] SP_CLEAR  = 3'd4;
  localparam logic [2:0] SP_LOAD   = 3'd5;

  localparam logic [WORD_W-1:0] MIDSCALE = 16'h8000;

  typedef struct packed {
    logic              rd;
    logic [3:0]        grp;
    logic [2:0]        ch;
    logic [WORD_W-1:0] data;
  } qdac_frame_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qdac_spi_frontend.sv
module qdac_spi_frontend
  import qdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [WORD_W-1:0] tx_word,
  output logic              frame_vld,
  output qdac_frame_t       frame,
  output logic              miso
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic                sclk_d, cs_d;
  logic [CNT_W-1:0]    bit_cnt;
  logic [FRAME_W-1:0]  rx_sh, tx_sh;
  logic                miso_q;
  logic                sclk_fall, sclk_rise, cs_start, cs_end;

  assign sclk_fall = sclk_d & ~sclk_s;
  assign sclk_rise = ~sclk_d & sclk_s;
  assign cs_start  = cs_d & ~cs_n_s;
  assign cs_end    = ~cs_d & cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      cs_d      <= 1'b1;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      miso_q    <= 1'b0;
      frame_vld <= 1'b0;
      frame     <= '0;
    end else begin
      sclk_d    <= sclk_s;
      cs_d      <= cs_n_s;
      frame_vld <= cs_end && (bit_cnt == CNT_FULL);
      if (cs_end) frame <= qdac_frame_t'(rx_sh);

      if (cs_start) begin
        bit_cnt <= '0;
        tx_sh   <= {{(FRAME_W-WORD_W){1'b0}}, tx_word};
        miso_q  <= 1'b0;
      end else if (!cs_n_s) begin
        if (sclk_fall) begin
          rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
          if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sclk_rise) begin
          miso_q <= tx_sh[FRAME_W-1];
          tx_sh  <= {tx_sh[FRAME_W-2:0], 1'b0};
        end
      end else begin
        miso_q <= 1'b0;
      end
    end
  end

  assign miso = miso_q;
endmodule

// File: rtl/qdac_regfile.sv
module qdac_regfile
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int RES    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_vld,
  input  qdac_frame_t           frame,
  output logic [WORD_W-1:0]     rd_word,
  output logic [NUM_CH*RES-1:0] dac_code,
  output logic [NUM_CH-1:0]     dac_update
);
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int PAD = WORD_W - RES;
  localparam logic [WORD_W-1:0] CODE_MASK = ~((16'h1 << PAD) - 16'h1);

  logic wr_en, ch_ok, do_clear, do_load;
  logic [WORD_W-1:0] code_rb   [NUM_CH];
  logic [WORD_W-1:0] coarse_rb [NUM_CH];
  logic [WORD_W-1:0] fine_rb   [NUM_CH];
  logic [WORD_W-1:0] offset_rb [NUM_CH];
  logic [WORD_W-1:0] cfg_q, rd_val, rd_word_q;

  assign wr_en    = frame_vld & ~frame.rd;
  assign ch_ok    = int'(frame.ch) < NUM_CH;
  assign do_clear = wr_en && frame.grp == GRP_SPECIAL && frame.ch == SP_CLEAR;
  assign do_load  = wr_en && frame.grp == GRP_SPECIAL && frame.ch == SP_LOAD;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              hit;
    logic [WORD_W-1:0] code_q;
    logic [1:0]        coarse_q;
    logic [5:0]        fine_q;
    logic [7:0]        offset_q;
    logic [RES-1:0]    out_q;
    logic              upd_q;

    assign hit = wr_en && ch_ok && (int'(frame.ch) == c);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q   <= MIDSCALE;
        coarse_q <= '0;
        fine_q   <= '0;
        offset_q <= '0;
        out_q    <= MIDSCALE[WORD_W-1 -: RES];
        upd_q    <= 1'b0;
      end else begin
        upd_q <= do_load;
        if (do_load) out_q <= code_q[WORD_W-1 -: RES];
        if (do_clear) code_q <= MIDSCALE;
        else if (hit && frame.grp == GRP_CODE) code_q <= frame.data & CODE_MASK;
        if (hit && frame.grp == GRP_COARSE) coarse_q <= frame.data[1:0];
        if (hit && frame.grp == GRP_FINE)   fine_q   <= frame.data[5:0];
        if (hit && frame.grp == GRP_OFFSET) offset_q <= frame.data[7:0];
      end
    end

    assign code_rb[c]   = code_q;
    assign coarse_rb[c] = {14'd0, coarse_q};
    assign fine_rb[c]   = {10'd0, fine_q};
    assign offset_rb[c] = {8'd0, offset_q};
    assign dac_code[c*RES +: RES] = out_q;
    assign dac_update[c] = upd_q;
  end

  always_comb begin
    rd_val = '0;
    case (frame.grp)
      GRP_SPECIAL: if (frame.ch == SP_CONFIG) rd_val = cfg_q;
      GRP_CODE:    if (ch_ok) rd_val = code_rb[frame.ch[CHW-1:0]];
      GRP_COARSE:  if (ch_ok) rd_val = coarse_rb[frame.ch[CHW-1:0]];
      GRP_FINE:    if (ch_ok) rd_val = fine_rb[frame.ch[CHW-1:0]];
      GRP_OFFSET:  if (ch_ok) rd_val = offset_rb[frame.ch[CHW-1:0]];
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      rd_word_q <= '0;
    end else if (frame_vld) begin
      rd_word_q <= frame.rd ? rd_val : '0;
      if (wr_en && frame.grp == GRP_SPECIAL && frame.ch == SP_CONFIG) cfg_q <= frame.data;
    end
  end

  assign rd_word = rd_word_q;
endmodule

// File: rtl/quad_dac_spi_regs.sv
module quad_dac_spi_regs
  import qdac_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int RES         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  mosi,
  output logic                  miso,
  output logic [NUM_CH*RES-1:0] dac_code,
  output logic [NUM_CH-1:0]     dac_update
);
  logic [2:0]        pins_s;
  logic              sclk_s, cs_n_s, mosi_s;
  logic              frame_vld;
  qdac_frame_t       frame;
  logic              frame_rd;
  logic [6:0]        frame_addr;
  logic [WORD_W-1:0] rd_word;

  qdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({mosi, cs_n, sclk}), .dout(pins_s)
  );
  assign sclk_s = pins_s[0];
  assign cs_n_s = pins_s[1];
  assign mosi_s = pins_s[2];

  qdac_spi_frontend u_front (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .tx_word(rd_word), .frame_vld(frame_vld), .frame(frame), .miso(miso)
  );

  qdac_regfile #(.NUM_CH(NUM_CH), .RES(RES)) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame(frame),
    .rd_word(rd_word), .dac_code(dac_code), .dac_update(dac_update)
  );

  assign frame_rd   = frame.rd;
  assign frame_addr = {frame.grp, frame.ch};
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
  parameter int NUM_CH = 4,
  parameter int RES    = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  frame_vld,
  input logic                  frame_rd,
  input logic [6:0]            frame_addr,
  input logic [15:0]           rd_word,
  input logic [NUM_CH*RES-1:0] dac_code,
  input logic [NUM_CH-1:0]     dac_update,
  input logic                  cs_n_s,
  input logic                  miso
);
  assert_single_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);

  assert_strobe_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(dac_update) == 0) || ($countones(dac_update) == NUM_CH));

  assert_load_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && !frame_rd && frame_addr == 7'h05) |=> ($countones(dac_update) == NUM_CH));

  assert_code_only_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> (dac_update != '0));

  assert_write_drops_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && !frame_rd) |=> (rd_word == 16'h0000));

  assert_miso_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !miso);
endmodule

bind quad_dac_spi_regs qdac_checker #(.NUM_CH(NUM_CH), .RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_rd(frame_rd),
  .frame_addr(frame_addr), .rd_word(rd_word), .dac_code(dac_code),
  .dac_update(dac_update), .cs_n_s(cs_n_s), .miso(miso)
);

// File: tb/quad_dac_spi_regs_tb.sv
`timescale 1ns/1ps
module quad_dac_spi_regs_tb;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso_a, miso_b;
  logic [63:0] code_a;
  logic [55:0] code_b;
  logic [3:0]  upd_a, upd_b;

  always #2.5 clk = ~clk;

  quad_dac_spi_regs #(.NUM_CH(4), .RES(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso_a), .dac_code(code_a), .dac_update(upd_a));
  quad_dac_spi_regs #(.NUM_CH(4), .RES(14)) u_dut_r14 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso_b), .dac_code(code_b), .dac_update(upd_b));

  int n_chk = 0, n_fail = 0;
  int stb_a = 0, stb_b = 0, stb_split = 0, m_loads = 0;
  logic [15:0] m_code [2][4];
  logic [15:0] m_out  [2][4];
  logic [15:0] m_pend [2];
  logic [1:0]  m_coarse [4];
  logic [5:0]  m_fine [4];
  logic [7:0]  m_off [4];
  logic [15:0] m_cfg;
  logic [23:0] rx_a, rx_b;

  always @(negedge clk) if (rst_n) begin
    if (upd_a != 4'h0) begin stb_a++; if (upd_a != 4'hF) stb_split++; end
    if (upd_b != 4'h0) begin stb_b++; if (upd_b != 4'hF) stb_split++; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wmask(input int r);
    return (r == 1) ? 16'hFFFC : 16'hFFFF;
  endfunction

  function automatic logic [15:0] mread(input int r, input logic [6:0] a);
    logic [3:0] g = a[6:3];
    logic [2:0] ch = a[2:0];
    if (g == 4'd0) return (ch == 3'd1) ? m_cfg : 16'h0;
    if (ch > 3'd3) return 16'h0;
    case (g)
      4'd2: return m_code[r][ch[1:0]];
      4'd3: return {14'h0, m_coarse[ch[1:0]]};
      4'd4: return {10'h0, m_fine[ch[1:0]]};
      4'd5: return {8'h0, m_off[ch[1:0]]};
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_reset();
    for (int r = 0; r < 2; r++) begin
      m_pend[r] = 16'h0;
      for (int c = 0; c < 4; c++) begin m_code[r][c] = 16'h8000; m_out[r][c] = 16'h8000; end
    end
    for (int c = 0; c < 4; c++) begin m_coarse[c] = 0; m_fine[c] = 0; m_off[c] = 0; end
    m_cfg = 16'h0;
  endtask

  task automatic model_commit(input logic [23:0] fr);
    logic [3:0] g = fr[22:19];
    logic [2:0] ch = fr[18:16];
    logic [15:0] d = fr[15:0];
    for (int r = 0; r < 2; r++) m_pend[r] = fr[23] ? mread(r, fr[22:16]) : 16'h0;
    if (fr[23]) return;
    if (g == 4'd0) begin
      if (ch == 3'd1) m_cfg = d;
      if (ch == 3'd4) for (int r = 0; r < 2; r++) for (int c = 0; c < 4; c++) m_code[r][c] = 16'h8000;
      if (ch == 3'd5) begin
        m_loads++;
        for (int r = 0; r < 2; r++) for (int c = 0; c < 4; c++) m_out[r][c] = m_code[r][c];
      end
    end else if (ch <= 3'd3) begin
      case (g)
        4'd2: for (int r = 0; r < 2; r++) m_code[r][ch[1:0]] = d & wmask(r);
        4'd3: m_coarse[ch[1:0]] = d[1:0];
        4'd4: m_fine[ch[1:0]] = d[5:0];
        4'd5: m_off[ch[1:0]] = d[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic spi_frame(input int nbits, input logic [23:0] fr);
    logic [15:0] pa, pb;
    pa = m_pend[0]; pb = m_pend[1];
    rx_a = '0; rx_b = '0;
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      mosi = (i < 24) ? fr[23-i] : 1'b0;
      repeat (10) @(negedge clk);
      rx_a = {rx_a[22:0], miso_a};
      rx_b = {rx_b[22:0], miso_b};
      sclk = 1'b0;
      repeat (10) @(negedge clk);
    end
    cs_n = 1'b1; mosi = 1'b0;
    repeat (12) @(negedge clk);
    if (nbits == 24) begin
      chk("R8 miso stream res16", {8'h0, rx_a}, {16'h0, pa});
      chk("R8 miso stream res14", {8'h0, rx_b}, {16'h0, pb});
      model_commit(fr);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    spi_frame(24, {1'b0, a, d});
  endtask

  task automatic rd_expect(input logic [6:0] a, input logic [15:0] e16,
                           input logic [15:0] e14, input string tag);
    spi_frame(24, {1'b1, a, 16'h0});
    spi_frame(24, 24'h0);
    chk(tag, {16'h0, rx_a[15:0]}, {16'h0, e16});
    chk(tag, {16'h0, rx_b[15:0]}, {16'h0, e14});
  endtask

  task automatic check_outputs(input string tag);
    for (int c = 0; c < 4; c++) begin
      chk(tag, {16'h0, code_a[c*16 +: 16]}, {16'h0, m_out[0][c]});
      chk(tag, {18'h0, code_b[c*14 +: 14]}, {18'h0, m_out[1][c][15:2]});
    end
    chk(tag, stb_a, m_loads);
    chk(tag, stb_b, m_loads);
    chk(tag, stb_split, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk("R10 miso idle", {31'h0, miso_a}, 0);
    chk("R10 miso idle r14", {31'h0, miso_b}, 0);
    check_outputs("R10 reset outputs");
    rd_expect(7'h10, 16'h8000, 16'h8000, "R10 code reset");
    rd_expect(7'h29, 16'h0000, 16'h0000, "R10 offset reset");

    // R1 bit order
    wr(7'h10, 16'h8001);
    rd_expect(7'h10, 16'h8001, 16'h8000, "R1 msb first");

    // R4 narrow code, R7 load
    wr(7'h12, 16'h1235);
    rd_expect(7'h12, 16'h1235, 16'h1234, "R4 low bits dropped");
    check_outputs("R7 no change before load");
    wr(7'h05, 16'h0000);
    check_outputs("R7 after load");
    chk("R4 bus res16", {16'h0, code_a[32 +: 16]}, 32'h1235);
    chk("R4 bus res14", {18'h0, code_b[28 +: 14]}, 32'h048D);

    // R5 narrow fields
    wr(7'h29, 16'hFF80);
    rd_expect(7'h29, 16'h0080, 16'h0080, "R5 offset -128");
    wr(7'h23, 16'hABE0);
    rd_expect(7'h23, 16'h0020, 16'h0020, "R5 fine gain -32");
    wr(7'h1B, 16'h0007);
    rd_expect(7'h1B, 16'h0003, 16'h0003, "R5 coarse two bits");

    // R9 config and nop
    wr(7'h01, 16'h5A5A);
    rd_expect(7'h01, 16'h5A5A, 16'h5A5A, "R9 config");
    wr(7'h00, 16'hFFFF);
    rd_expect(7'h00, 16'h0000, 16'h0000, "R9 nop reads zero");

    // R3 routing and ignored addresses
    wr(7'h20, 16'h0005);
    rd_expect(7'h20, 16'h0005, 16'h0005, "R3 fine ch0");
    rd_expect(7'h10, 16'h8001, 16'h8000, "R3 code ch0 untouched");
    wr(7'h16, 16'h7777);
    rd_expect(7'h16, 16'h0000, 16'h0000, "R3 channel 6 absent");
    wr(7'h31, 16'h1111);
    rd_expect(7'h11, 16'h8000, 16'h8000, "R3 group 6 ignored");

    // R2 wrong lengths
    spi_frame(23, {1'b0, 7'h12, 16'hAAAA});
    spi_frame(25, {1'b0, 7'h12, 16'h5555});
    spi_frame(23, {1'b0, 7'h05, 16'h0000});
    rd_expect(7'h12, 16'h1235, 16'h1234, "R2 bad length ignored");
    check_outputs("R2 no load from bad length");

    // R6 clear
    wr(7'h04, 16'h0000);
    rd_expect(7'h12, 16'h8000, 16'h8000, "R6 clear to midscale");
    chk("R6 bus held", {16'h0, code_a[32 +: 16]}, 32'h1235);
    wr(7'h05, 16'h0000);
    chk("R6 bus after load", {16'h0, code_a[32 +: 16]}, 32'h8000);
    chk("R6 bus after load r14", {18'h0, code_b[28 +: 14]}, 32'h2000);

    // R8 read has no side effects
    wr(7'h13, 16'h4444);
    spi_frame(24, {1'b1, 7'h04, 16'h0000});
    spi_frame(24, {1'b1, 7'h05, 16'h0000});
    rd_expect(7'h13, 16'h4444, 16'h4444, "R8 read of clear is inert");
    check_outputs("R8 read of load is inert");

    // random frames
    for (int it = 0; it < 90; it++) begin
      int sel;
      logic [3:0] g;
      logic [23:0] fr;
      sel = $urandom_range(0, 11);
      case ($urandom_range(0, 6))
        0: g = 4'd0;
        1: g = 4'd2;
        2: g = 4'd3;
        3: g = 4'd4;
        4: g = 4'd5;
        5: g = 4'd2;
        default: g = 4'($urandom_range(0, 15));
      endcase
      fr = {($urandom_range(0, 2) == 0), g, 3'($urandom_range(0, 7)), 16'($urandom())};
      if (sel == 0) spi_frame((($urandom_range(0, 1) == 0) ? 23 : 25), fr);
      else spi_frame(24, fr);
      check_outputs("R3 R7 random traffic");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule